// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a 34-bit physical address by walking a page table with two levels of 1024 four-byte entries over 4 KiB pages. A start pulse captures the address, the access kind (fetch, load or store), the privilege, the root page number, the translation enable and the status controls. The walker then issues single-word reads on a request/response memory port until it finds a leaf entry or hits a fault. Each entry it reads is checked for validity, reserved encodings, user/supervisor ownership, superpage alignment and access permission.

When a valid leaf does not yet have its accessed bit set, or lacks its dirty bit on a store, the walker sends an atomic compare-and-swap on the same port. If another agent changed the entry in between, the compare fails and the whole walk starts again from the root. The result is a physical address with read, write and execute permissions, or a page fault with its cause code. The result stays on the outputs from the done pulse until the next start.

Top module: `pt_walk2`

## Requirements
- R1: After reset, and whenever it is idle, the block has busy, done and memory request low. A start while idle raises busy on the next cycle. Done is high for exactly one cycle per walk. Starts while busy are ignored.
- R2: The effective privilege is the input privilege, except for a load or store at machine privilege (3) with the modify-privilege flag set, where it becomes the previous-privilege field. A fetch never uses the previous-privilege field. Access encodings are fetch 0, load 1, store 2, with 3 treated as load. Privilege encodings are user 0, supervisor 1, machine 3.
- R3: With translation disabled, or with effective privilege machine, the physical address is the zero-extended virtual address with read, write and execute all granted. No memory access is made.
- R4: Each entry is read from the word at base*4096 + index*4. The first read indexes with VA[31:22] from the root page number. The second read indexes with VA[21:12] from the page number of the pointer entry. A request holds its address until acknowledged.
- R5: An entry with the valid bit (bit 0) clear faults, and so does a read answered with an error.
- R6: A leaf with write (bit 2) set and read (bit 1) clear faults. This covers the write-only and write-plus-execute encodings.
- R7: A page with the user bit (bit 4) set faults when the effective privilege is not user and either the supervisor-user-access flag is clear or the access is a fetch. A page with the user bit clear faults when the effective privilege is not supervisor.
- R8: A first-level leaf whose page number (entry bits 31:10) has any of its low 10 bits set faults.
- R9: A load needs read, or execute (bit 3) together with the make-executable-readable flag. A store needs write. A fetch needs execute. The reported read permission is read, or execute with that flag. Execute permission follows the execute bit.
- R10: A leaf passing all checks needs accessed (bit 6) set, and dirty (bit 7) as well on a store. Otherwise a compare-and-swap is sent with the entry as compare value and the entry with those bits set as write value. An error answer to the swap is a fault.
- R11: If the swap reports a compare mismatch, the walk restarts with a fresh first-level read from the root.
- R12: A first-level leaf maps a 4 MiB superpage: the physical address takes bits 21:12 from the virtual address. Write permission is granted only on a store or when the leaf's dirty bit is already set.
- R13: A pointer entry (read, write and execute all clear) found at the second level faults.
- R14: A fault reports cause 12 for fetch, 13 for load and 15 for store, with the physical address and all permissions zero. A success reports cause 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a translation (taken only when idle) |
| va_i | input | 32 | Virtual address |
| acc_i | input | 2 | Access kind: 0 fetch, 1 load, 2 store |
| priv_i | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| paged_i | input | 1 | Translation enabled (0 = bare) |
| root_ppn_i | input | 22 | Page number of the first-level table |
| sum_i | input | 1 | Supervisor may access user pages |
| mxr_i | input | 1 | Execute-only pages readable by loads |
| mprv_i | input | 1 | Loads/stores use previous privilege |
| mpp_i | input | 2 | Previous privilege |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle result strobe |
| fault_o | output | 1 | Translation faulted |
| cause_o | output | 4 | Fault cause code, 0 on success |
| pa_o | output | 34 | Physical address |
| rd_o | output | 1 | Read permitted |
| wr_o | output | 1 | Write permitted |
| ex_o | output | 1 | Execute permitted |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a compare-and-swap |
| mem_addr_o | output | 34 | Entry address |
| mem_wdata_o | output | 32 | Swap write value |
| mem_cmp_o | output | 32 | Swap compare value |
| mem_ack_i | input | 1 | Request completed this cycle |
| mem_err_i | input | 1 | Access error (read error or unwritable region) |
| mem_cas_ok_i | input | 1 | Swap compare matched and the write happened |
| mem_rdata_i | input | 32 | Read data |

## Verification
The bench builds the walker with its default parameters: 12 offset bits, 10 index bits and a 22-bit page number. Entry addresses therefore pass 32 bits, and a pointer whose page number sets bit 20 lands outside the modelled memory, so the read-error fault can be reached. The 10-bit index width makes the superpage alignment rule bite on bits 9:0 of the page number, and one leaf has only bit 0 set there. The modelled memory can be told to report one swap mismatch while another agent sets the accessed bit, which reaches the re-walk path. One page answers swaps with an error, which reaches the unwritable-entry fault.

// File: rtl/pt_walk2_pkg.sv
package pt_walk2_pkg;
  localparam int unsigned PTE_PPN_LSB = 10;
  localparam int unsigned B_V = 0;
  localparam int unsigned B_R = 1;
  localparam int unsigned B_W = 2;
  localparam int unsigned B_X = 3;
  localparam int unsigned B_U = 4;
  localparam int unsigned B_A = 6;
  localparam int unsigned B_D = 7;

  localparam logic [1:0] ACC_FETCH = 2'd0;
  localparam logic [1:0] ACC_STORE = 2'd2;
  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_M = 2'd3;

  localparam logic [3:0] CAUSE_FETCH = 4'd12;
  localparam logic [3:0] CAUSE_LOAD  = 4'd13;
  localparam logic [3:0] CAUSE_STORE = 4'd15;

  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_CAS, ST_DONE} walk_st_e;
  typedef enum logic [1:0] {PK_FAULT, PK_NEXT, PK_LEAF} pte_kind_e;
endpackage

// File: rtl/pt_walk2_priv.sv
module pt_walk2_priv
  import pt_walk2_pkg::*;
(
  input  logic [1:0] priv_i,
  input  logic [1:0] acc_i,
  input  logic       mprv_i,
  input  logic [1:0] mpp_i,
  output logic [1:0] eff_o,
  output logic       mach_o
);
  always_comb begin
    eff_o = priv_i;
    if (priv_i == PRIV_M && acc_i != ACC_FETCH && mprv_i) eff_o = mpp_i;
    mach_o = (eff_o == PRIV_M);
  end
endmodule

// File: rtl/pt_walk2_check.sv
module pt_walk2_check
  import pt_walk2_pkg::*;
#(
  parameter int unsigned XW    = 32,
  parameter int unsigned PPN_W = 22,
  parameter int unsigned IDX_W = 10
) (
  input  logic [XW-1:0]    pte_i,
  input  logic             top_i,
  input  logic [1:0]       acc_i,
  input  logic [1:0]       eff_i,
  input  logic             sum_i,
  input  logic             mxr_i,
  output pte_kind_e        kind_o,
  output logic [PPN_W-1:0] ppn_o,
  output logic [XW-1:0]    upd_o,
  output logic             need_upd_o,
  output logic             rd_o,
  output logic             wr_o,
  output logic             ex_o
);
  logic v, r, w, x, u, d;
  logic is_fetch, is_store, is_load;
  logic bad;

  assign v = pte_i[B_V];
  assign r = pte_i[B_R];
  assign w = pte_i[B_W];
  assign x = pte_i[B_X];
  assign u = pte_i[B_U];
  assign d = pte_i[B_D];
  assign ppn_o = pte_i[PTE_PPN_LSB +: PPN_W];

  assign is_fetch = (acc_i == ACC_FETCH);
  assign is_store = (acc_i == ACC_STORE);
  assign is_load  = !is_fetch && !is_store;

  always_comb begin
    bad = 1'b0;
    if (w && !r) bad = 1'b1;                                  // reserved encodings
    if (u && eff_i != PRIV_U && (!sum_i || is_fetch)) bad = 1'b1;
    if (!u && eff_i != PRIV_S) bad = 1'b1;
    if (top_i && ppn_o[IDX_W-1:0] != '0) bad = 1'b1;          // misaligned superpage
    if (is_load && !(r || (x && mxr_i))) bad = 1'b1;
    if (is_store && !w) bad = 1'b1;
    if (is_fetch && !x) bad = 1'b1;

    if (!v)                 kind_o = PK_FAULT;
    else if (!(r | w | x))  kind_o = top_i ? PK_NEXT : PK_FAULT;
    else if (bad)           kind_o = PK_FAULT;
    else                    kind_o = PK_LEAF;
  end

  always_comb begin
    upd_o = pte_i;
    upd_o[B_A] = 1'b1;
    if (is_store) upd_o[B_D] = 1'b1;
  end

  assign need_upd_o = (upd_o != pte_i);
  assign rd_o = r | (x & mxr_i);
  assign ex_o = x;
  assign wr_o = w & (is_store | d);
endmodule

// File: rtl/pt_walk2.sv
module pt_walk2
  import pt_walk2_pkg::*;
#(
  parameter int unsigned OFF_W = 12,
  parameter int unsigned IDX_W = 10,
  parameter int unsigned PPN_W = 22,
  parameter int unsigned XW    = 32,
  localparam int unsigned VA_W   = OFF_W + 2 * IDX_W,
  localparam int unsigned PA_W   = PPN_W + OFF_W,
  localparam int unsigned ENT_SH = $clog2(XW / 8)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [VA_W-1:0]  va_i,
  input  logic [1:0]       acc_i,
  input  logic [1:0]       priv_i,
  input  logic             paged_i,
  input  logic [PPN_W-1:0] root_ppn_i,
  input  logic             sum_i,
  input  logic             mxr_i,
  input  logic             mprv_i,
  input  logic [1:0]       mpp_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             fault_o,
  output logic [3:0]       cause_o,
  output logic [PA_W-1:0]  pa_o,
  output logic             rd_o,
  output logic             wr_o,
  output logic             ex_o,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [PA_W-1:0]  mem_addr_o,
  output logic [XW-1:0]    mem_wdata_o,
  output logic [XW-1:0]    mem_cmp_o,
  input  logic             mem_ack_i,
  input  logic             mem_err_i,
  input  logic             mem_cas_ok_i,
  input  logic [XW-1:0]    mem_rdata_i
);
  walk_st_e         st_q;
  logic [VA_W-1:0]  va_q;
  logic [1:0]       acc_q, eff_q;
  logic             sum_q, mxr_q, top_q;
  logic [PPN_W-1:0] root_q, base_q;
  logic [XW-1:0]    pte_q, upd_q;
  logic [PA_W-1:0]  pa_q;
  logic             fault_q, rd_q, wr_q, ex_q;
  logic [3:0]       cause_q;

  logic [1:0]       eff_now;
  logic             mach_now;
  pte_kind_e        kind;
  logic [PPN_W-1:0] ppn;
  logic [XW-1:0]    upd;
  logic             need_upd, c_rd, c_wr, c_ex;
  logic [IDX_W-1:0] idx;
  logic [PA_W-1:0]  pte_addr, leaf_pa;
  logic [3:0]       fault_cause;

  pt_walk2_priv u_priv (
    .priv_i (priv_i),
    .acc_i  (acc_i),
    .mprv_i (mprv_i),
    .mpp_i  (mpp_i),
    .eff_o  (eff_now),
    .mach_o (mach_now)
  );

  pt_walk2_check #(.XW(XW), .PPN_W(PPN_W), .IDX_W(IDX_W)) u_check (
    .pte_i      (mem_rdata_i),
    .top_i      (top_q),
    .acc_i      (acc_q),
    .eff_i      (eff_q),
    .sum_i      (sum_q),
    .mxr_i      (mxr_q),
    .kind_o     (kind),
    .ppn_o      (ppn),
    .upd_o      (upd),
    .need_upd_o (need_upd),
    .rd_o       (c_rd),
    .wr_o       (c_wr),
    .ex_o       (c_ex)
  );

  assign idx = top_q ? va_q[VA_W-1 -: IDX_W] : va_q[OFF_W +: IDX_W];
  assign pte_addr = {base_q, {OFF_W{1'b0}}} + PA_W'({idx, {ENT_SH{1'b0}}});
  assign leaf_pa = top_q ? {ppn[PPN_W-1:IDX_W], va_q[OFF_W +: IDX_W], va_q[OFF_W-1:0]}
                         : {ppn, va_q[OFF_W-1:0]};

  always_comb begin
    unique case (acc_q)
      ACC_FETCH: fault_cause = CAUSE_FETCH;
      ACC_STORE: fault_cause = CAUSE_STORE;
      default:   fault_cause = CAUSE_LOAD;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      va_q    <= '0;
      acc_q   <= '0;
      eff_q   <= '0;
      sum_q   <= 1'b0;
      mxr_q   <= 1'b0;
      top_q   <= 1'b1;
      root_q  <= '0;
      base_q  <= '0;
      pte_q   <= '0;
      upd_q   <= '0;
      pa_q    <= '0;
      fault_q <= 1'b0;
      cause_q <= '0;
      rd_q    <= 1'b0;
      wr_q    <= 1'b0;
      ex_q    <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          va_q   <= va_i;
          acc_q  <= acc_i;
          eff_q  <= eff_now;
          sum_q  <= sum_i;
          mxr_q  <= mxr_i;
          root_q <= root_ppn_i;
          base_q <= root_ppn_i;
          top_q  <= 1'b1;
          if (!paged_i || mach_now) begin
            pa_q    <= PA_W'(va_i);
            {rd_q, wr_q, ex_q} <= 3'b111;
            fault_q <= 1'b0;
            cause_q <= '0;
            st_q    <= ST_DONE;
          end else begin
            st_q <= ST_READ;
          end
        end
        ST_READ: if (mem_ack_i) begin
          if (mem_err_i || kind == PK_FAULT) begin
            pa_q    <= '0;
            {rd_q, wr_q, ex_q} <= 3'b000;
            fault_q <= 1'b1;
            cause_q <= fault_cause;
            st_q    <= ST_DONE;
          end else if (kind == PK_NEXT) begin
            base_q <= ppn;
            top_q  <= 1'b0;
          end else begin
            pa_q    <= leaf_pa;
            {rd_q, wr_q, ex_q} <= {c_rd, c_wr, c_ex};
            fault_q <= 1'b0;
            cause_q <= '0;
            if (need_upd) begin
              pte_q <= mem_rdata_i;
              upd_q <= upd;
              st_q  <= ST_CAS;
            end else begin
              st_q <= ST_DONE;
            end
          end
        end
        ST_CAS: if (mem_ack_i) begin
          if (mem_err_i) begin
            pa_q    <= '0;
            {rd_q, wr_q, ex_q} <= 3'b000;
            fault_q <= 1'b1;
            cause_q <= fault_cause;
            st_q    <= ST_DONE;
          end else if (!mem_cas_ok_i) begin
            base_q <= root_q;  // entry changed: walk again from the root
            top_q  <= 1'b1;
            st_q   <= ST_READ;
          end else begin
            st_q <= ST_DONE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o      = (st_q != ST_IDLE);
  assign done_o      = (st_q == ST_DONE);
  assign fault_o     = fault_q;
  assign cause_o     = cause_q;
  assign pa_o        = pa_q;
  assign rd_o        = rd_q;
  assign wr_o        = wr_q;
  assign ex_o        = ex_q;
  assign mem_req_o   = (st_q == ST_READ) || (st_q == ST_CAS);
  assign mem_we_o    = (st_q == ST_CAS);
  assign mem_addr_o  = pte_addr;
  assign mem_wdata_o = upd_q;
  assign mem_cmp_o   = pte_q;
endmodule

// File: rtl/pt_walk2_sva.sv
module pt_walk2_sva #(
  parameter int unsigned PA_W = 34,
  parameter int unsigned XW   = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            start_i,
  input logic            busy_o,
  input logic            done_o,
  input logic            fault_o,
  input logic [3:0]      cause_o,
  input logic [PA_W-1:0] pa_o,
  input logic            rd_o,
  input logic            wr_o,
  input logic            ex_o,
  input logic            mem_req_o,
  input logic            mem_we_o,
  input logic            mem_ack_i,
  input logic [PA_W-1:0] mem_addr_o,
  input logic [XW-1:0]   mem_wdata_o,
  input logic [XW-1:0]   mem_cmp_o
);
  localparam logic [XW-1:0] AD_MASK = XW'(8'hC0);

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!mem_req_o && !done_o)); // R1
  AST_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o); // R1
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R1
  AST_ENTRY_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_addr_o[1:0] == 2'b00)); // R4
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o))); // R4
  AST_CAS_ONLY_AD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |-> (((mem_wdata_o ^ mem_cmp_o) & ~AD_MASK) == '0
                                 && mem_wdata_o[6] && mem_wdata_o != mem_cmp_o)); // R10
  AST_FAULT_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && fault_o) |-> (!rd_o && !wr_o && !ex_o && pa_o == '0)); // R14
  AST_CAUSE_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (fault_o ? (cause_o == 4'd12 || cause_o == 4'd13 || cause_o == 4'd15)
                        : (cause_o == 4'd0))); // R14
endmodule

bind pt_walk2 pt_walk2_sva #(.PA_W(PA_W), .XW(XW)) u_sva (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .fault_o     (fault_o),
  .cause_o     (cause_o),
  .pa_o        (pa_o),
  .rd_o        (rd_o),
  .wr_o        (wr_o),
  .ex_o        (ex_o),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_ack_i   (mem_ack_i),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .mem_cmp_o   (mem_cmp_o)
);

// File: tb/pt_walk2_test.sv
`timescale 1ns/1ps
module pt_walk2_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] va = '0;
  logic [1:0]  acc = '0, priv = '0, mpp = '0;
  logic        paged = 1'b0, sum = 1'b0, mxr = 1'b0, mprv = 1'b0;
  logic [21:0] root = '0;
  logic        busy, done, fault, rd, wr, ex;
  logic [3:0]  cause;
  logic [33:0] pa;
  logic        mem_req, mem_we, mem_ack, mem_err, cas_ok;
  logic [33:0] mem_addr;
  logic [31:0] mem_wdata, mem_cmp, mem_rdata;

  int checks = 0;
  int errors = 0;
  int tx_cnt = 0;
  logic [33:0] addr_log [8];
  logic cas_fail_arm = 1'b0;
  logic [31:0] mem [4096];

  always #2.5 clk = ~clk;

  pt_walk2 uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .va_i(va), .acc_i(acc),
    .priv_i(priv), .paged_i(paged), .root_ppn_i(root), .sum_i(sum), .mxr_i(mxr),
    .mprv_i(mprv), .mpp_i(mpp), .busy_o(busy), .done_o(done), .fault_o(fault),
    .cause_o(cause), .pa_o(pa), .rd_o(rd), .wr_o(wr), .ex_o(ex),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_cmp_o(mem_cmp), .mem_ack_i(mem_ack),
    .mem_err_i(mem_err), .mem_cas_ok_i(cas_ok), .mem_rdata_i(mem_rdata)
  );

  // Memory model: pages 0..3 exist, page 2 rejects swaps, same-cycle ack.
  logic in_range;
  always_comb begin
    in_range  = (mem_addr[33:14] == '0);
    mem_ack   = mem_req;
    mem_rdata = in_range ? mem[mem_addr[13:2]] : 32'h0;
    mem_err   = mem_req && (!in_range || (mem_we && mem_addr[13:12] == 2'd2));
    cas_ok    = mem_we && in_range && !cas_fail_arm && (mem[mem_addr[13:2]] == mem_cmp);
  end

  always @(posedge clk) begin
    if (mem_req) begin
      if (tx_cnt < 8) addr_log[tx_cnt] <= mem_addr;
      tx_cnt <= tx_cnt + 1;
      if (mem_we && !mem_err) begin
        if (cas_fail_arm) begin
          mem[mem_addr[13:2]] <= mem[mem_addr[13:2]] | 32'h40; // other agent sets A
          cas_fail_arm <= 1'b0;
        end else if (mem[mem_addr[13:2]] == mem_cmp) begin
          mem[mem_addr[13:2]] <= mem_wdata;
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic walk(input logic [31:0] a, input logic [1:0] k, input logic [1:0] p,
                      input logic pg, input logic s, input logic m, input logic mp,
                      input logic [1:0] pp, input logic [21:0] rt);
    @(negedge clk);
    va = a; acc = k; priv = p; paged = pg; sum = s; mxr = m; mprv = mp; mpp = pp; root = rt;
    tx_cnt = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 40 && !done; i++) @(negedge clk);
  endtask

  typedef struct packed {
    logic [31:0] va;
    logic [1:0]  acc;
    logic [1:0]  priv;
    logic        paged, sum, mxr, mprv;
    logic [1:0]  mpp;
    logic        fault;
    logic [3:0]  cause;
    logic [33:0] pa;
    logic [2:0]  rwx;
    logic [3:0]  req;
  } vec_t;

  // acc: 0 fetch 1 load 2 store; priv: 0 U 1 S 3 M
  localparam vec_t VT [23] = '{
    '{32'h00001ABC, 2'd1, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 4'd0,  34'h000ABCABC, 3'b101, 4'd9},  // R9 load
    '{32'h00001ABC, 2'd0, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 4'd0,  34'h000ABCABC, 3'b101, 4'd9},  // R9 fetch
    '{32'h00001ABC, 2'd2, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 4'd15, 34'h0,         3'b000, 4'd9},  // R9 store no W
    '{32'h00000010, 2'd1, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 4'd0,  34'h012345010, 3'b111, 4'd7},  // R7 user on user page
    '{32'h00000010, 2'd1, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 4'd13, 34'h0,         3'b000, 4'd7},  // R7 S no SUM
    '{32'h00000010, 2'd1, 2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 4'd0,  34'h012345010, 3'b111, 4'd7},  // R7 S with SUM
    '{32'h00000010, 2'd0, 2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 2'd0, 1'b1, 4'd12, 34'h0,         3'b000, 4'd7},  // R7 S fetch user page
    '{32'h00001ABC, 2'd1, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 4'd13, 34'h0,         3'b000, 4'd7},  // R7 U on S page
    '{32'h00555678, 2'd1, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 4'd0,  34'h000555678, 3'b111, 4'd12}, // R12 superpage
    '{32'h00800000, 2'd1, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 4'd13, 34'h0,         3'b000, 4'd8},  // R8 misaligned
    '{32'h00C00000, 2'd0, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 4'd12, 34'h0,         3'b000, 4'd5},  // R5 invalid
    '{32'h01000000, 2'd1, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 4'd13, 34'h0,         3'b000, 4'd5},  // R5 read error
    '{32'h01400000, 2'd2, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 4'd15, 34'h0,         3'b000, 4'd6},  // R6 W only
    '{32'h00005000, 2'd1, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 4'd13, 34'h0,         3'b000, 4'd6},  // R6 W+X
    '{32'h00003000, 2'd1, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 4'd13, 34'h0,         3'b000, 4'd13}, // R13 pointer at leaf level
    '{32'h00004000, 2'd1, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 4'd13, 34'h0,         3'b000, 4'd9},  // R9 X-only no MXR
    '{32'h00004000, 2'd1, 2'd1, 1'b1, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0, 4'd0,  34'h000321000, 3'b101, 4'd9},  // R9 X-only with MXR
    '{32'hDEADBEEF, 2'd1, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 4'd0,  34'h0DEADBEEF, 3'b111, 4'd3},  // R3 machine
    '{32'h00001004, 2'd1, 2'd3, 1'b1, 1'b0, 1'b0, 1'b1, 2'd1, 1'b0, 4'd0,  34'h000ABC004, 3'b101, 4'd2},  // R2 MPRV -> S
    '{32'h00001004, 2'd0, 2'd3, 1'b1, 1'b0, 1'b0, 1'b1, 2'd0, 1'b0, 4'd0,  34'h000001004, 3'b111, 4'd2},  // R2 fetch ignores MPRV
    '{32'h12345678, 2'd1, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 4'd0,  34'h012345678, 3'b111, 4'd3},  // R3 bare
    '{32'h00001004, 2'd1, 2'd3, 1'b1, 1'b0, 1'b0, 1'b1, 2'd0, 1'b1, 4'd13, 34'h0,         3'b000, 4'd2},  // R2 MPRV -> U on S page
    '{32'h00002008, 2'd1, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 4'd0,  34'h000777008, 3'b100, 4'd12}  // R12 no D, load: no write
  };

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R1 watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 32'h0;
    // first-level table at page 0
    mem[0] = 32'h00000401;  // pointer -> page 1
    mem[1] = 32'h001000CF;  // aligned superpage RWX A D
    mem[2] = 32'h001004C3;  // misaligned superpage
    mem[4] = 32'h40000001;  // pointer outside memory
    mem[5] = 32'h000000C5;  // W-only
    mem[6] = 32'h00000801;  // pointer -> page 2 (swap rejected)
    // second-level table at page 1
    mem[1024] = 32'h048D14DF;
    mem[1025] = 32'h002AF04B;
    mem[1026] = 32'h001DDC47;
    mem[1027] = 32'h00001401;
    mem[1028] = 32'h000C8449;
    mem[1029] = 32'h000000CD;
    mem[1030] = 32'h00115803;
    mem[2048] = 32'h00266403;
    mem[3072] = 32'h00000401;  // alternate root at page 3

    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {60'h0, busy, done, mem_req, fault}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", {62'h0, busy, mem_req}, 64'h0);

    foreach (VT[n]) begin
      walk(VT[n].va, VT[n].acc, VT[n].priv, VT[n].paged, VT[n].sum, VT[n].mxr,
           VT[n].mprv, VT[n].mpp, 22'h0);
      checks++;
      if ({done, fault, cause, pa, rd, wr, ex} !== {1'b1, VT[n].fault, VT[n].cause, VT[n].pa, VT[n].rwx}) begin
        errors++;
        $display("FAIL R%0d vec %0d actual=%h expected=%h", VT[n].req, n,
                 {done, fault, cause, pa, rd, wr, ex},
                 {1'b1, VT[n].fault, VT[n].cause, VT[n].pa, VT[n].rwx});
      end
      @(negedge clk);
      chk("R1 done one cycle", {63'h0, done}, 64'h0);
    end

    // R3: pass-through makes no memory access
    walk(32'h00001004, 2'd1, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 22'h0);
    chk("R3 no access", 64'(tx_cnt), 64'd0);

    // R10 store sets D by swap; R4 addresses; R12 write granted on store
    walk(32'h00002008, 2'd2, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 22'h0);
    chk("R12 store result", {fault, pa, rd, wr, ex}, {1'b0, 34'h000777008, 3'b110});
    chk("R10 access count", 64'(tx_cnt), 64'd3);
    chk("R4 root entry addr", 64'(addr_log[0]), 64'h0);
    chk("R4 leaf entry addr", 64'(addr_log[1]), 64'h1008);
    chk("R10 entry updated", 64'(mem[1026]), 64'h001DDCC7);
    walk(32'h00002008, 2'd1, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 22'h0);
    chk("R12 dirty grants write", {fault, rd, wr, ex}, {1'b0, 3'b110});
    chk("R10 no swap when set", 64'(tx_cnt), 64'd2);

    // R11 swap mismatch -> full re-walk
    cas_fail_arm = 1'b1;
    walk(32'h00006010, 2'd1, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 22'h0);
    chk("R11 result after restart", {fault, pa, rd, wr, ex}, {1'b0, 34'h000456010, 3'b100});
    chk("R11 access count", 64'(tx_cnt), 64'd5);
    chk("R11 restart at root", 64'(addr_log[3]), 64'h0);
    chk("R11 entry state", 64'(mem[1030]), 64'h00115843);

    // R10 swap error on unwritable page
    walk(32'h01800000, 2'd1, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 22'h0);
    chk("R10 swap error fault", {fault, cause}, {1'b1, 4'd13});
    chk("R4 root idx 6 addr", 64'(addr_log[0]), 64'h18);
    chk("R4 second base page 2", 64'(addr_log[1]), 64'h2000);
    chk("R10 unwritable unchanged", 64'(mem[2048]), 64'h00266403);

    // R4 non-zero root page number
    walk(32'h00001004, 2'd1, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 22'h3);
    chk("R4 alt root result", {fault, pa}, {1'b0, 34'h000ABC004});
    chk("R4 alt root addr", 64'(addr_log[0]), 64'h3000);

    // R1 start while busy is ignored
    @(negedge clk);
    va = 32'h00001ABC; acc = 2'd1; priv = 2'd1; paged = 1'b1; root = 22'h0;
    start = 1'b1;
    @(negedge clk);
    va = 32'h00000010;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 40 && !done; i++) @(negedge clk);
    chk("R1 busy start ignored", {fault, pa}, {1'b0, 34'h000ABCABC});
    @(negedge clk);
    chk("R1 back to idle", {63'h0, busy}, 64'h0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule